// File: doc/BRIEF.md
# Erasable Read-Only Memory Mode Controller

This block is a synthesizable behavioural model of the control logic around a byte-wide, ultraviolet-erasable read-only memory. On every clock it samples the three active-low strobes (chip select, output gate and program pulse), a flag for the raised programming supply and a flag for the raised voltage on address line 9. From these it settles one of seven operating modes. All outputs are registered, so they appear one clock after the inputs are sampled.

In read and verify modes the stored byte at the addressed location is driven. In signature mode one of two fixed identifier bytes is driven. In program mode the data inputs are merged into the stored byte. Programming can only clear bits, so only an erase can bring a bit back to 1. The erase is a synchronous whole-array command. A strobe combination that the mode table does not list is handled as output-disable and reported with a one-cycle error pulse.

The address port is 14 bits wide, which covers a full 16,384-byte device. The stored depth is a parameter (`STORE_AW`), so a configuration with `STORE_AW = 14` gives the full array. The default keeps 2**10 bytes, and the upper address bits then alias onto them.

Top module: `eprom_ctl`

## Requirements
- R1: The array holds 2**STORE_AW bytes indexed by the low STORE_AW address bits. After reset every byte reads 0xFF.
- R2: With e_n high, data_oe is 0, data_out is 0 and no byte is written, whatever g_n, p_n or a9_high are. mode is 0 (standby) when vpp_high is 0 and 1 (program-inhibit) when it is 1.
- R3: With e_n=0, g_n=0, p_n=1, vpp_high=0 and a9_high=0, mode is 2 (read), data_oe is 1 and data_out is the stored byte, one clock after the sample.
- R4: With e_n=0, g_n=1, p_n=1 and vpp_high=0, mode is 3 (output disable), data_oe is 0 and data_out is 0.
- R5: With e_n=0, g_n=1, p_n=0 and vpp_high=1, mode is 4 (program) and data_oe is 0. Each clock in this mode stores the old byte ANDed with data_in, so bits only go from 1 to 0.
- R6: With e_n=0, g_n=0, p_n=1 and vpp_high=1, mode is 5 (verify), data_oe is 1 and data_out is the stored byte. a9_high has no effect in this mode.
- R7: With e_n=0, g_n=0, p_n=1, vpp_high=0 and a9_high=1, mode is 6 (signature) and data_oe is 1. If every address bit other than bit 0 and bit 9 is 0, data_out is 0x20 for address bit 0 = 0 and 0x89 for address bit 0 = 1.
- R8: In signature mode, if any address bit other than bit 0 and bit 9 is 1, sig_addr_err is 1 and data_out is 0xFF. In every other case sig_addr_err is 0.
- R9: Any strobe and supply combination not listed in R2 to R7 gives mode 3 and data_oe 0. bad_combo is 1 for exactly one cycle, on the first sample of such a combination.
- R10: When erase is sampled high at an edge, every byte becomes 0xFF at the next edge. Program pulses sampled at either of those two edges are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; array returns to all ones |
| addr | input | ADDR_W | Byte address |
| e_n | input | 1 | Active-low chip select |
| g_n | input | 1 | Active-low output gate |
| p_n | input | 1 | Active-low program pulse |
| vpp_high | input | 1 | Programming supply present |
| a9_high | input | 1 | High-voltage level on address line 9 |
| data_in | input | DATA_W | Byte presented for programming |
| erase | input | 1 | Whole-array erase command |
| data_out | output | DATA_W | Registered output byte, 0 when not driving |
| data_oe | output | 1 | Bus drive enable (0 means high impedance) |
| mode | output | 3 | Current mode code (encoding in R2 to R7) |
| bad_combo | output | 1 | One-cycle pulse on entering an unlisted combination |
| sig_addr_err | output | 1 | Signature read with a forbidden address bit set |

## Verification
The assertions assume that the strobes, flags and address are stable across each rising edge. They also assume that the first sampled values after reset are meaningful levels rather than unknowns. The stimulus changes every input only on the falling clock edge and starts from a defined idle pattern of chip deselected with no supply. The error-pulse property assumes only that a combination may be held for several cycles. The stimulus deliberately holds an unlisted pattern for two cycles, so that property sees both its rising and its held case.

// File: rtl/eprom_pkg.sv
package eprom_pkg;

   typedef enum logic [2:0] {
      MD_STANDBY   = 3'd0,
      MD_INHIBIT   = 3'd1,
      MD_READ      = 3'd2,
      MD_OUTDIS    = 3'd3,
      MD_PROGRAM   = 3'd4,
      MD_VERIFY    = 3'd5,
      MD_SIGNATURE = 3'd6
   } mode_e;

   function automatic logic mode_drives(input mode_e m);
      return (m == MD_READ) || (m == MD_VERIFY) || (m == MD_SIGNATURE);
   endfunction

endpackage

// File: rtl/eprom_mode_dec.sv
module eprom_mode_dec
   import eprom_pkg::*;
(
   input  logic  e_n,
   input  logic  g_n,
   input  logic  p_n,
   input  logic  vpp_high,
   input  logic  a9_high,
   output mode_e mode,
   output logic  unlisted
);

   always_comb begin
      mode     = MD_OUTDIS;
      unlisted = 1'b0;
      if (e_n) begin
         mode = vpp_high ? MD_INHIBIT : MD_STANDBY;
      end else if (!vpp_high) begin
         unique case ({g_n, p_n})
            2'b01:   mode = a9_high ? MD_SIGNATURE : MD_READ;
            2'b11:   mode = MD_OUTDIS;
            default: unlisted = 1'b1;
         endcase
      end else begin
         unique case ({g_n, p_n})
            2'b10:   mode = MD_PROGRAM;
            2'b01:   mode = MD_VERIFY;
            default: unlisted = 1'b1;
         endcase
      end
   end

endmodule

// File: rtl/eprom_sig_unit.sv
module eprom_sig_unit #(
   parameter int unsigned          ADDR_W   = 14,
   parameter int unsigned          DATA_W   = 8,
   parameter int unsigned          HV_BIT   = 9,
   parameter logic [DATA_W-1:0]    MFR_CODE = 8'h20,
   parameter logic [DATA_W-1:0]    DEV_CODE = 8'h89
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [DATA_W-1:0] sig_byte,
   output logic              addr_bad
);

   localparam logic [ADDR_W-1:0] ONE_A    = {{(ADDR_W-1){1'b0}}, 1'b1};
   localparam logic [ADDR_W-1:0] FREE_MSK = ONE_A | (ONE_A << HV_BIT);
   localparam logic [ADDR_W-1:0] CHK_MSK  = ~FREE_MSK;

   if (HV_BIT >= ADDR_W || HV_BIT == 0) begin : g_bad_hv
      $error("eprom_sig_unit: HV_BIT must lie in 1..ADDR_W-1");
   end

   if (DATA_W < 8) begin : g_bad_w
      $error("eprom_sig_unit: DATA_W must be at least 8");
   end

   assign addr_bad = |(addr & CHK_MSK);
   assign sig_byte = addr[0] ? DEV_CODE : MFR_CODE;

endmodule

// File: rtl/eprom_array.sv
module eprom_array #(
   parameter int unsigned STORE_AW = 10,
   parameter int unsigned DATA_W   = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [STORE_AW-1:0] idx,
   input  logic                wr_en,
   input  logic [DATA_W-1:0]   wr_data,
   input  logic                erase_now,
   output logic [DATA_W-1:0]   rd_data
);

   localparam int unsigned DEPTH = 1 << STORE_AW;

   if (STORE_AW < 1 || STORE_AW > 14) begin : g_bad_depth
      $error("eprom_array: STORE_AW must lie in 1..14");
   end

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
      end else if (erase_now) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
      end else if (wr_en) begin
         mem[idx] <= mem[idx] & wr_data;
      end
   end

   assign rd_data = mem[idx];

   // R10
   erase_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      erase_now |=> (rd_data == '1));

endmodule

// File: rtl/eprom_ctl.sv
module eprom_ctl
   import eprom_pkg::*;
#(
   parameter int unsigned       ADDR_W   = 14,
   parameter int unsigned       DATA_W   = 8,
   parameter int unsigned       STORE_AW = 10,
   parameter int unsigned       HV_BIT   = 9,
   parameter logic [DATA_W-1:0] MFR_CODE = 8'h20,
   parameter logic [DATA_W-1:0] DEV_CODE = 8'h89
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              e_n,
   input  logic              g_n,
   input  logic              p_n,
   input  logic              vpp_high,
   input  logic              a9_high,
   input  logic [DATA_W-1:0] data_in,
   input  logic              erase,
   output logic [DATA_W-1:0] data_out,
   output logic              data_oe,
   output logic [2:0]        mode,
   output logic              bad_combo,
   output logic              sig_addr_err
);

   if (STORE_AW > ADDR_W) begin : g_bad_store
      $error("eprom_ctl: STORE_AW exceeds ADDR_W");
   end

   mode_e             md_now;
   logic              unlisted;
   logic              erase_q;
   logic              wr_en;
   logic [DATA_W-1:0] rd_data;
   logic [DATA_W-1:0] sig_byte;
   logic              addr_bad;
   logic              unl_q;
   mode_e             mode_q;

   eprom_mode_dec u_dec (
      .e_n      (e_n),
      .g_n      (g_n),
      .p_n      (p_n),
      .vpp_high (vpp_high),
      .a9_high  (a9_high),
      .mode     (md_now),
      .unlisted (unlisted)
   );

   eprom_sig_unit #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .HV_BIT   (HV_BIT),
      .MFR_CODE (MFR_CODE),
      .DEV_CODE (DEV_CODE)
   ) u_sig (
      .addr     (addr),
      .sig_byte (sig_byte),
      .addr_bad (addr_bad)
   );

   assign wr_en = (md_now == MD_PROGRAM) && !erase && !erase_q;

   eprom_array #(
      .STORE_AW (STORE_AW),
      .DATA_W   (DATA_W)
   ) u_arr (
      .clk       (clk),
      .rst_n     (rst_n),
      .idx       (addr[STORE_AW-1:0]),
      .wr_en     (wr_en),
      .wr_data   (data_in),
      .erase_now (erase_q),
      .rd_data   (rd_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         erase_q      <= 1'b0;
         mode_q       <= MD_STANDBY;
         data_oe      <= 1'b0;
         data_out     <= '0;
         unl_q        <= 1'b0;
         bad_combo    <= 1'b0;
         sig_addr_err <= 1'b0;
      end else begin
         erase_q      <= erase;
         mode_q       <= md_now;
         data_oe      <= mode_drives(md_now);
         unl_q        <= unlisted;
         bad_combo    <= unlisted && !unl_q;
         sig_addr_err <= (md_now == MD_SIGNATURE) && addr_bad;
         unique case (md_now)
            MD_READ, MD_VERIFY: data_out <= rd_data;
            MD_SIGNATURE:       data_out <= addr_bad ? '1 : sig_byte;
            default:            data_out <= '0;
         endcase
      end
   end

   assign mode = mode_q;

   // R2
   standby_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
      e_n |=> (!data_oe && (mode == 3'd0 || mode == 3'd1)));

   // R4
   outdis_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!e_n && g_n) |=> !data_oe);

   // R7
   sig_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 3'd6 && !sig_addr_err) |-> (data_out == MFR_CODE || data_out == DEV_CODE));

   // R8
   sig_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sig_addr_err |-> (data_out == '1 && data_oe));

   // R9
   bad_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bad_combo |=> !bad_combo);

endmodule

// File: tb/sim_eprom_ctl.sv
module sim_eprom_ctl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [13:0] addr = '0;
   logic        e_n = 1'b1, g_n = 1'b1, p_n = 1'b1;
   logic        vpp_high = 1'b0, a9_high = 1'b0, erase = 1'b0;
   logic [7:0]  data_in = '0;
   logic [7:0]  data_out;
   logic        data_oe;
   logic [2:0]  mode;
   logic        bad_combo, sig_addr_err;

   always #4 clk = ~clk;

   eprom_ctl u0 (
      .clk(clk), .rst_n(rst_n), .addr(addr), .e_n(e_n), .g_n(g_n), .p_n(p_n),
      .vpp_high(vpp_high), .a9_high(a9_high), .data_in(data_in), .erase(erase),
      .data_out(data_out), .data_oe(data_oe), .mode(mode),
      .bad_combo(bad_combo), .sig_addr_err(sig_addr_err)
   );

   typedef struct {
      logic [2:0] md;
      logic       oe;
      logic [7:0] dat;
      logic       bad;
      logic       sig;
      string      tag;
   } exp_t;

   exp_t exp_q[$];
   int checks = 0;
   int errors = 0;
   bit done = 0;

   task automatic step(input logic en, input logic gn, input logic pn,
                       input logic vpp, input logic a9, input logic [13:0] a,
                       input logic [7:0] din, input logic ers,
                       input logic [2:0] md, input logic oe, input logic [7:0] dat,
                       input logic bad, input logic sig, input string tag);
      exp_t x;
      @(negedge clk);
      e_n = en; g_n = gn; p_n = pn; vpp_high = vpp; a9_high = a9;
      addr = a; data_in = din; erase = ers;
      x.md = md; x.oe = oe; x.dat = dat; x.bad = bad; x.sig = sig; x.tag = tag;
      exp_q.push_back(x);
   endtask

   // monitor: compares one item per clock, 2 ns after the edge
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (exp_q.size() > 0) begin
            exp_t x;
            x = exp_q.pop_front();
            checks++;
            if (mode !== x.md || data_oe !== x.oe || data_out !== x.dat ||
                bad_combo !== x.bad || sig_addr_err !== x.sig) begin
               errors++;
               $display("FAIL %s: got mode=%0d oe=%0b data=%h bad=%0b sig=%0b, exp mode=%0d oe=%0b data=%h bad=%0b sig=%0b",
                        x.tag, mode, data_oe, data_out, bad_combo, sig_addr_err,
                        x.md, x.oe, x.dat, x.bad, x.sig);
            end
         end
      end
   end

   initial begin
      // reset state (R1, R2)
      #1;
      checks++;
      if (mode !== 3'd0 || data_oe !== 1'b0 || data_out !== 8'h00 || bad_combo !== 1'b0) begin
         errors++;
         $display("FAIL R2 reset: mode=%0d oe=%0b data=%h, exp 0 0 00", mode, data_oe, data_out);
      end
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      //    en gn pn vpp a9 addr     din  ers  md oe dat  bad sig tag
      step(1, 1, 1, 0, 0, 14'h000, 8'h00, 0, 0, 0, 8'h00, 0, 0, "R2 idle standby");
      step(0, 0, 1, 0, 0, 14'h005, 8'h00, 0, 2, 1, 8'hFF, 0, 0, "R1 R3 erased read");
      step(1, 0, 0, 0, 1, 14'h005, 8'h00, 0, 0, 0, 8'h00, 0, 0, "R2 standby G/P low");
      step(1, 1, 0, 1, 0, 14'h005, 8'h00, 0, 1, 0, 8'h00, 0, 0, "R2 inhibit");
      step(0, 0, 1, 0, 0, 14'h005, 8'h00, 0, 2, 1, 8'hFF, 0, 0, "R2 inhibit wrote nothing");
      step(0, 1, 0, 1, 0, 14'h005, 8'hF0, 0, 4, 0, 8'h00, 0, 0, "R5 program F0");
      step(0, 0, 1, 1, 0, 14'h005, 8'h00, 0, 5, 1, 8'hF0, 0, 0, "R6 verify F0");
      step(0, 1, 0, 1, 0, 14'h005, 8'h3C, 0, 4, 0, 8'h00, 0, 0, "R5 program 3C");
      step(0, 0, 1, 1, 1, 14'h005, 8'h00, 0, 5, 1, 8'h30, 0, 0, "R5 R6 AND merge 30");
      step(0, 1, 0, 1, 0, 14'h3FF, 8'hA5, 0, 4, 0, 8'h00, 0, 0, "R5 program top");
      step(0, 0, 1, 0, 0, 14'h3FF, 8'h00, 0, 2, 1, 8'hA5, 0, 0, "R1 R3 read top");
      step(0, 0, 1, 0, 0, 14'h005, 8'h00, 0, 2, 1, 8'h30, 0, 0, "R3 read 30");
      step(0, 1, 1, 0, 0, 14'h005, 8'h00, 0, 3, 0, 8'h00, 0, 0, "R4 output disable");
      step(0, 0, 1, 0, 1, 14'h000, 8'h00, 0, 6, 1, 8'h20, 0, 0, "R7 sig byte 0");
      step(0, 0, 1, 0, 1, 14'h001, 8'h00, 0, 6, 1, 8'h89, 0, 0, "R7 sig byte 1");
      step(0, 0, 1, 0, 1, 14'h201, 8'h00, 0, 6, 1, 8'h89, 0, 0, "R7 sig with bit 9");
      step(0, 0, 1, 0, 1, 14'h004, 8'h00, 0, 6, 1, 8'hFF, 0, 1, "R8 sig bad bit 2");
      step(0, 0, 1, 0, 1, 14'h2000, 8'h00, 0, 6, 1, 8'hFF, 0, 1, "R8 sig bad bit 13");
      step(0, 0, 0, 0, 0, 14'h005, 8'h00, 0, 3, 0, 8'h00, 1, 0, "R9 unlisted first");
      step(0, 0, 0, 0, 0, 14'h005, 8'h00, 0, 3, 0, 8'h00, 0, 0, "R9 unlisted held");
      step(0, 0, 1, 0, 0, 14'h005, 8'h00, 0, 2, 1, 8'h30, 0, 0, "R9 no write by unlisted");
      step(0, 1, 0, 0, 0, 14'h005, 8'h00, 0, 3, 0, 8'h00, 1, 0, "R9 P low no supply");
      step(0, 0, 0, 1, 0, 14'h005, 8'h00, 0, 3, 0, 8'h00, 0, 0, "R9 G,P low with supply held");
      step(0, 0, 1, 0, 0, 14'h005, 8'h00, 0, 2, 1, 8'h30, 0, 0, "R9 still 30");
      step(0, 1, 0, 1, 0, 14'h006, 8'h00, 1, 4, 0, 8'h00, 0, 0, "R10 erase with pulse");
      step(0, 1, 0, 1, 0, 14'h007, 8'h00, 0, 4, 0, 8'h00, 0, 0, "R10 pulse during erase");
      step(0, 0, 1, 0, 0, 14'h007, 8'h00, 0, 2, 1, 8'hFF, 0, 0, "R10 addr 7 discarded");
      step(0, 0, 1, 0, 0, 14'h006, 8'h00, 0, 2, 1, 8'hFF, 0, 0, "R10 addr 6 discarded");
      step(0, 0, 1, 0, 0, 14'h005, 8'h00, 0, 2, 1, 8'hFF, 0, 0, "R10 addr 5 erased");
      step(0, 0, 1, 0, 0, 14'h3FF, 8'h00, 0, 2, 1, 8'hFF, 0, 0, "R10 top erased");
      step(1, 1, 1, 0, 0, 14'h000, 8'h00, 0, 0, 0, 8'h00, 0, 0, "R2 back to standby");

      wait (exp_q.size() == 0);
      @(posedge clk);
      #3;
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run did not complete, exp done=1 got 0");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule